// File: doc/BRIEF.md
# Composite Frame Sync Aligner

This block takes an external transmit sync line and builds the transmit frame timing from it. The sync line runs beside the transmit clock and is sampled directly on that clock, with no asynchronous crossing. Only rising edges carry meaning. A plain 8 kHz square wave, with a frame start every 125 µs, is therefore a legal sync. The line may also be a composite pulse train. In that case short pulses mark every frame start, and extra pulses at a fixed marker position in three of every four frames give a 2 kHz multiframe reference. A payload-pointer pulse is not needed on the line.

Inside the block a free-running position counter steps through bit, then STS slot, then column, then row. Its frame length follows a rate-select input: 12 interleaved STS slots per column, or 3. Four offset inputs (row, column, STS, bit) choose where in the frame the frame-start strobe fires. With all offsets at zero, the strobe falls one clock after a sync edge that lands on the frame boundary.

A locked flag reports that sync edges keep landing on the boundary. A single out-of-place edge is tolerated. A second one, with no boundary edge in between, realigns the counter. In composite mode a two-bit multiframe phase is recovered from the marker pulses.

Top module: `frame_sync_aligner`

## Requirements
- R1: Only a low-to-high change of `sync_i` between two consecutive clocks counts as a sync edge. A level held high or low produces no further edges, so a 50 % duty square wave with one rising edge per frame reaches lock. After reset the previous sync value is taken as high.
- R2: The position counter advances once per clock. The bit field counts fastest, then STS slot, then column, then row. After ROWS × COLS × slots × BITS clocks it returns to the origin, so with fixed offsets `frame_start_o` repeats with exactly that period.
- R3: `rate_i` = 1 gives 12 STS slots per column and `rate_i` = 0 gives 3. This sets the frame length to ROWS × COLS × 12 × BITS or ROWS × COLS × 3 × BITS clocks.
- R4: `frame_start_o` is high in exactly those clocks where all four counter fields equal `off_row_i`, `off_col_i`, `off_sts_i` and `off_bit_i`. With all offsets zero, that is the clock after a boundary edge.
- R5: The first sync edge after reset realigns the counter: the next clock is position 0 (the origin), and `locked_o` stays low.
- R6: A sync edge seen while the counter is at its last position (row, column, slot and bit all at their maximum) is a boundary edge. It sets `locked_o` in the next clock.
- R7: A single stray edge is ignored. A stray edge is one that is neither a boundary edge nor, in composite mode, a marker edge. It leaves the counter timing and `locked_o` unchanged.
- R8: A second stray edge with no boundary edge since the first realigns the counter to position 0 in the next clock and clears `locked_o`.
- R9: With `composite_i` = 1, an edge at position (row MARK_ROW, column MARK_COL, slot 0, bit 0) is a marker and is never stray. A marker in a frame that follows a frame without a marker sets `mf_phase_o` to 1 in the next clock. With `composite_i` = 0 the same edge is stray and leaves the phase alone.
- R10: `mf_phase_o` increments modulo 4 on each counter wrap and returns to 0 on every realignment.
- R11: After reset `locked_o` = 0, `mf_phase_o` = 0, and the counter is at the origin, so `frame_start_o` is high then only if all offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one counter position per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | External sync line, synchronous to clk |
| rate_i | input | 1 | 1: 12 STS slots per column, 0: 3 slots |
| composite_i | input | 1 | 1: sync line carries multiframe markers |
| off_bit_i | input | BIT_W | Frame-start offset, bit field |
| off_sts_i | input | STS_W | Frame-start offset, STS slot field |
| off_col_i | input | COL_W | Frame-start offset, column field |
| off_row_i | input | ROW_W | Frame-start offset, row field |
| frame_start_o | output | 1 | One-clock frame-start strobe |
| mf_phase_o | output | 2 | Multiframe phase, 0 to 3 |
| locked_o | output | 1 | Sync edges are landing on the frame boundary |

## Verification
The bench drives four kinds of sync stimulus and compares all outputs against a behavioural model on every clock.

- A 50 % duty square wave at the short rate separates rising-edge detection from level sensing and shows lock being reached. Moving the offsets to a non-zero point shows the strobe following all four fields.
- Shifting the square wave by part of a frame separates the tolerated first stray edge from the realigning second one, and shows lock returning afterwards.
- A composite train with frame and marker pulses at the long rate separates marker edges from stray edges and tracks the four-frame phase.
- The same train with composite mode turned off shows the markers being treated as isolated strays that neither move the phase nor break lock.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef logic [1:0] mf_phase_t;

    typedef enum logic {
        RATE_LOW  = 1'b0,
        RATE_HIGH = 1'b1
    } rate_e;

endpackage

// File: rtl/fsa_edge_detect.sv
module fsa_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end

    assign rise_o = sync_i & ~st_q.prev;

    // R1: an edge needs low in the previous clock and high now
    a_r1_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (sync_i && !$past(sync_i)));

endmodule

// File: rtl/fsa_pos_counter.sv
module fsa_pos_counter #(
    parameter int ROWS  = 9,
    parameter int COLS  = 90,
    parameter int BITS  = 8,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS),
    parameter int STS_W = 4,
    parameter int BIT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [STS_W-1:0] sts_last_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic [STS_W-1:0] sts_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             wrap_o
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [STS_W-1:0] sts;
        logic [BIT_W-1:0] bt;
    } pos_t;

    pos_t pos_d, pos_q;
    logic bit_end, sts_end, col_end, row_end;

    always_comb begin
        bit_end = (pos_q.bt == BIT_LAST);
        sts_end = (pos_q.sts >= sts_last_i);
        col_end = (pos_q.col == COL_LAST);
        row_end = (pos_q.row == ROW_LAST);
        pos_d   = pos_q;
        if (clr_i) begin
            pos_d = '0;
        end else if (!bit_end) begin
            pos_d.bt = pos_q.bt + BIT_W'(1);
        end else begin
            pos_d.bt = '0;
            if (!sts_end) begin
                pos_d.sts = pos_q.sts + STS_W'(1);
            end else begin
                pos_d.sts = '0;
                if (!col_end) begin
                    pos_d.col = pos_q.col + COL_W'(1);
                end else begin
                    pos_d.col = '0;
                    pos_d.row = row_end ? '0 : pos_q.row + ROW_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign row_o  = pos_q.row;
    assign col_o  = pos_q.col;
    assign sts_o  = pos_q.sts;
    assign bit_o  = pos_q.bt;
    assign wrap_o = bit_end & sts_end & col_end & row_end;

    // R2: after the last position the counter is back at the origin
    a_r2_wrap_to_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !clr_i) |=> (row_o == '0 && col_o == '0 && sts_o == '0 && bit_o == '0));

    // R5 / R8: a realignment puts the counter at the origin
    a_r5_clear_to_origin: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (row_o == '0 && col_o == '0 && sts_o == '0 && bit_o == '0));

    // R2: fields stay inside their ranges
    a_r2_fields_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bit_o) < BITS) && (int'(col_o) < COLS) && (int'(row_o) < ROWS));

endmodule

// File: rtl/fsa_lock_ctrl.sv
module fsa_lock_ctrl
    import fsa_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      edge_i,
    input  logic      wrap_i,
    input  logic      at_mark_i,
    output logic      realign_o,
    output logic      locked_o,
    output mf_phase_t phase_o
);

    typedef struct packed {
        logic      aligned;
        logic      strike;
        logic      locked;
        logic      seen;
        logic      lastm;
        mf_phase_t phase;
    } lk_st_t;

    localparam lk_st_t LK_RESET = '{aligned: 1'b0, strike: 1'b0, locked: 1'b0,
                                    seen: 1'b0, lastm: 1'b1, phase: 2'd0};

    lk_st_t st_d, st_q;
    logic   good, stray, mark_e, realign;

    always_comb begin
        good    = edge_i & wrap_i;
        mark_e  = edge_i & at_mark_i;
        stray   = edge_i & ~wrap_i & ~at_mark_i;
        realign = edge_i & (~st_q.aligned | (stray & st_q.strike));
        st_d    = st_q;
        if (realign) begin
            st_d         = LK_RESET;
            st_d.aligned = 1'b1;
        end else begin
            if (good) begin
                st_d.strike = 1'b0;
                st_d.locked = 1'b1;
            end else if (stray) begin
                st_d.strike = 1'b1;
            end
            if (wrap_i) begin
                st_d.seen  = 1'b0;
                st_d.lastm = st_q.seen;
                st_d.phase = st_q.phase + 2'd1;
            end else if (mark_e) begin
                st_d.seen = 1'b1;
                if (!st_q.lastm) st_d.phase = 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_RESET;
        else        st_q <= st_d;
    end

    assign realign_o = realign;
    assign locked_o  = st_q.locked;
    assign phase_o   = st_q.phase;

    // R8: a realignment always drops lock
    a_r8_realign_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |=> !locked_o);

    // R6: lock only rises after an edge on the frame boundary
    a_r6_lock_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(edge_i && wrap_i));

    // R10: the phase steps by one on every undisturbed wrap
    a_r10_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !realign_o) |=> (phase_o == $past(phase_o) + 2'd1));

    // R7: a lone stray edge neither realigns nor drops lock
    a_r7_single_stray_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !wrap_i && !at_mark_i && !st_q.strike && st_q.aligned && locked_o)
            |=> locked_o);

endmodule

// File: rtl/frame_sync_aligner.sv
module frame_sync_aligner
    import fsa_pkg::*;
#(
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int BITS     = 8,
    parameter int STS_HI   = 12,
    parameter int STS_LO   = 3,
    parameter int MARK_ROW = 3,
    parameter int MARK_COL = 0,
    parameter int ROW_W    = $clog2(ROWS),
    parameter int COL_W    = $clog2(COLS),
    parameter int STS_W    = $clog2(STS_HI),
    parameter int BIT_W    = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             rate_i,
    input  logic             composite_i,
    input  logic [BIT_W-1:0] off_bit_i,
    input  logic [STS_W-1:0] off_sts_i,
    input  logic [COL_W-1:0] off_col_i,
    input  logic [ROW_W-1:0] off_row_i,
    output logic             frame_start_o,
    output logic [1:0]       mf_phase_o,
    output logic             locked_o
);

    localparam logic [STS_W-1:0] STS_LAST_HI = STS_W'(STS_HI - 1);
    localparam logic [STS_W-1:0] STS_LAST_LO = STS_W'(STS_LO - 1);
    localparam logic [ROW_W-1:0] MARK_R      = ROW_W'(MARK_ROW);
    localparam logic [COL_W-1:0] MARK_C      = COL_W'(MARK_COL);

    logic             rise, wrap, at_mark, realign;
    logic [STS_W-1:0] sts_last;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [STS_W-1:0] sts;
    logic [BIT_W-1:0] bt;
    mf_phase_t        phase;

    assign sts_last = (rate_i == RATE_HIGH) ? STS_LAST_HI : STS_LAST_LO;

    fsa_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .rise_o (rise)
    );

    fsa_pos_counter #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .BITS  (BITS),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .STS_W (STS_W),
        .BIT_W (BIT_W)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (realign),
        .sts_last_i (sts_last),
        .row_o      (row),
        .col_o      (col),
        .sts_o      (sts),
        .bit_o      (bt),
        .wrap_o     (wrap)
    );

    assign at_mark = composite_i && (row == MARK_R) && (col == MARK_C)
                     && (sts == '0) && (bt == '0);

    fsa_lock_ctrl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (rise),
        .wrap_i    (wrap),
        .at_mark_i (at_mark),
        .realign_o (realign),
        .locked_o  (locked_o),
        .phase_o   (phase)
    );

    assign frame_start_o = (row == off_row_i) && (col == off_col_i)
                           && (sts == off_sts_i) && (bt == off_bit_i);
    assign mf_phase_o    = phase;

    // R4: with zero offsets a boundary edge is followed by the strobe
    a_r4_strobe_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && wrap && off_row_i == '0 && off_col_i == '0 && off_sts_i == '0
         && off_bit_i == '0 && $stable(off_bit_i)) |=> frame_start_o);

endmodule

// File: tb/frame_sync_aligner_bench.sv
`timescale 1ns/1ps
module frame_sync_aligner_bench;

    localparam int TR = 3, TC = 4, TB = 2, MR = 1, MC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic       rate = 1'b0;
    logic       comp = 1'b0;
    logic [0:0] ob = '0;
    logic [3:0] os = '0;
    logic [1:0] oc = '0;
    logic [1:0] orw = '0;
    logic       fs;
    logic [1:0] ph;
    logic       lk;

    always #2 clk = ~clk;

    frame_sync_aligner #(
        .ROWS(TR), .COLS(TC), .BITS(TB), .STS_HI(12), .STS_LO(3),
        .MARK_ROW(MR), .MARK_COL(MC)
    ) u_frame_sync_aligner (
        .clk(clk), .rst_n(rst_n), .sync_i(sync), .rate_i(rate),
        .composite_i(comp), .off_bit_i(ob), .off_sts_i(os), .off_col_i(oc),
        .off_row_i(orw), .frame_start_o(fs), .mf_phase_o(ph), .locked_o(lk)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    bit want_rst_n = 1'b0;
    // behavioural reference state
    int m_prev, m_pos, m_al, m_strike, m_lock, m_seen, m_lastm, m_phase;
    // generator state
    int g_pos = 0, g_frame = 0, g_mode = 0;
    int cyc = 0, last_fs = -1, gap = 0;

    function automatic int nsts();
        return rate ? 12 : 3;
    endfunction
    function automatic int flen();
        return TR * TC * nsts() * TB;
    endfunction
    function automatic int mlin();
        return ((MR * TC + MC) * nsts()) * TB;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = 1; m_pos = 0; m_al = 0; m_strike = 0;
        m_lock = 0; m_seen = 0; m_lastm = 1; m_phase = 0;
    endtask

    function automatic bit gen_sync();
        if (g_mode == 0) return g_pos < flen() / 2;
        return (g_pos < 3) || ((g_frame % 4 != 0) && g_pos >= mlin() + 1 && g_pos < mlin() + 4);
    endfunction

    task automatic model_cycle();
        int  f, offl, exp_fs;
        bit  edg, wrp, atm, good, stray, mark_e, realign;
        f      = flen();
        offl   = ((int'(orw) * TC + int'(oc)) * nsts() + int'(os)) * TB + int'(ob);
        exp_fs = (m_pos == offl) ? 1 : 0;
        chk(fs == exp_fs[0], "R2 R4 frame_start", fs, exp_fs);
        chk(lk == m_lock[0], "R6 R7 R8 locked", lk, m_lock);
        chk(int'(ph) == m_phase, "R9 R10 phase", ph, m_phase);
        if (fs) begin
            if (last_fs >= 0) gap = cyc - last_fs;
            last_fs = cyc;
        end
        cyc++;
        edg     = sync && (m_prev == 0);
        wrp     = (m_pos == f - 1);
        atm     = comp && (m_pos == mlin());
        good    = edg && wrp;
        stray   = edg && !wrp && !atm;
        mark_e  = edg && atm;
        realign = edg && (m_al == 0 || (stray && m_strike == 1));
        m_prev  = sync;
        if (realign) begin
            model_reset();
            m_prev = 1'(sync);
            m_al   = 1;
        end else begin
            m_pos = wrp ? 0 : m_pos + 1;
            if (good) begin m_strike = 0; m_lock = 1; end
            else if (stray) m_strike = 1;
            if (wrp) begin
                m_lastm = m_seen; m_seen = 0; m_phase = (m_phase + 1) % 4;
            end else if (mark_e) begin
                if (m_lastm == 0) m_phase = 1;
                m_seen = 1;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        rst_n = want_rst_n;
        sync  = want_rst_n ? gen_sync() : 1'b0;
        @(negedge clk);
        if (!rst_n) model_reset();
        else begin
            model_cycle();
            g_pos++;
            if (g_pos >= flen()) begin g_pos = 0; g_frame++; end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_until(input int fr, input int p);
        while (!(g_frame == fr && g_pos == p)) step();
    endtask

    task automatic do_reset();
        want_rst_n = 1'b0;
        g_pos = 0; g_frame = 0; last_fs = -1; gap = 0;
        run(3);
        // R11: reset state at the ports
        chk(lk == 1'b0, "R11 locked after reset", lk, 0);
        chk(ph == 2'd0, "R11 phase after reset", ph, 0);
        chk(fs == (orw == 0 && oc == 0 && os == 0 && ob == 0), "R11 strobe at origin", fs, 1);
        want_rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int p100;
        model_reset();
        // square wave, short rate, zero offsets
        rate = 1'b0; comp = 1'b0; g_mode = 0;
        do_reset();
        run(5);
        chk(lk == 1'b0, "R5 not locked after first edge", lk, 0);
        run(5 * 72 - 5);
        chk(lk == 1'b1, "R1 R6 square wave locks", lk, 1);
        chk(gap == 72, "R2 strobe period short rate", gap, 72);
        // non-zero offsets in all four fields
        orw = 2'd2; oc = 2'd3; os = 4'd2; ob = 1'b1;
        run(144);
        chk(gap == 72, "R4 offset strobe period", gap, 72);
        // shift the sync by part of a frame
        g_pos = (g_pos + 10) % 72;
        run(72);
        chk(lk == 1'b1, "R7 lone stray edge ignored", lk, 1);
        run(72);
        chk(lk == 1'b0, "R8 second stray realigns", lk, 0);
        run(144);
        chk(lk == 1'b1, "R6 relocked after realign", lk, 1);
        // composite train, long rate
        orw = '0; oc = '0; os = '0; ob = '0;
        rate = 1'b1; comp = 1'b1; g_mode = 1;
        do_reset();
        run_until(9, 150);
        chk(ph == 2'd1, "R9 marker after empty frame gives phase 1", ph, 1);
        run_until(10, 10);
        chk(ph == 2'd2, "R10 phase steps on wrap", ph, 2);
        chk(gap == 288, "R3 strobe period long rate", gap, 288);
        chk(lk == 1'b1, "R6 composite train locks", lk, 1);
        // markers with composite mode off
        comp = 1'b0;
        run_until(13, 100);
        p100 = int'(ph);
        run_until(13, 200);
        chk(int'(ph) == p100, "R9 marker ignored for phase when not composite", ph, p100);
        run_until(16, 50);
        chk(lk == 1'b1, "R7 isolated marker strays keep lock", lk, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule